// File: doc/BRIEF.md
# Three-Slot Frame Commit Tracker

This block keeps track of up to three configuration lists for a frame-driven loader. Each list is named by a small handle. One list is the active list, which the hardware is currently using. One is the queued list, whose header address has been handed to the loader. One is the pending list, which is held back because the loader has not yet taken the previous update. Software commits new lists at any time. The tracker decides whether a commit can go to the loader now or must wait. On each frame-end strobe it moves the lists forward between the slots and reports what completed.

The block works in one of two modes. In continuous mode a committed list keeps running until a newer one replaces it. A commit that races the loader is parked in the pending slot, and the newest parked commit wins. Completion is delayed by one frame when the loader has not yet taken its header or when a bottom field ends. In single-shot mode a commit goes straight to the active slot, and every frame end retires that list.

Each list that leaves the tracker is handed back through a release strobe. A drain input empties all three slots in a fixed order.

Top module: `fct_commit_tracker`

## Requirements
- R1: While `rst_n` is low, every output strobe and flag is 0 and all slots become empty. A frame end after reset in continuous mode reports `fe_valid`=1 with `fe_completed`=0.
- R2: In continuous mode, take a commit that arrives when the loader is not busy. The loader is busy when the queued slot is occupied and either `upd_pending` is 1 or a header was written by a frame end in the same cycle. Such a commit pulses `hdr_wr` with its handle one cycle later. If the queued slot held an older list, that list is released in the same cycle. The committed list becomes the queued list.
- R3: In continuous mode, a commit that arrives while the loader is busy writes no header. It becomes the pending list, and any list already in the pending slot is released.
- R4: When a commit replaces a pending list that carries the internal flag, `warn_replace` pulses together with that list's release.
- R5: In single-shot mode, a commit writes its header and becomes the active list at once. Every frame end releases the active list, if there is one, and reports completed=1.
- R6: In continuous mode, a frame end does nothing when the queued slot is occupied and `upd_pending` is 1. It reports `fe_valid`=1 with completed=0.
- R7: In continuous mode, a frame end with `bottom_field`=1 changes no slot and reports completed=0.
- R8: At a continuous-mode frame end that is not deferred, an active list carrying the writeback flag causes `fe_writeback`=1. That flag is then cleared, so a later frame end on the same list reports writeback=0.
- R9: At a continuous-mode frame end that is not deferred and has a queued list, several things happen. `fe_internal` equals the queued list's internal flag. The old active list is released. The queued list becomes active with its internal flag cleared. `fe_completed`=1.
- R10: After that promotion, a pending list has its header written, on `hdr_wr` in the same report cycle, and it moves into the queued slot.
- R11: A one-cycle `drain` pulse releases three slots on three consecutive cycles: the active list first, then the queued list, then the pending list. A strobe is given only for an occupied slot. Commits and frame ends presented during those three cycles are ignored.
- R12: When a commit and a frame end arrive in the same cycle, the frame end is applied first. The commit then sees the slots the frame end left behind.
- R13: `upd_pending` has no effect while the queued slot is empty. A commit then goes straight to the loader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_shot | input | 1 | 1 selects single-shot mode, 0 selects continuous mode |
| upd_pending | input | 1 | Loader has not yet taken the last written header |
| bottom_field | input | 1 | The frame now ending is a bottom field |
| frame_end | input | 1 | Frame-end strobe |
| commit_valid | input | 1 | Commit request strobe |
| commit_handle | input | HANDLE_W | Handle of the committed list |
| commit_internal | input | 1 | Committed list wants internal notification |
| commit_writeback | input | 1 | Committed list performs writeback capture |
| drain | input | 1 | Start releasing all three slots |
| hdr_wr | output | 1 | Write a list header address to the loader |
| hdr_handle | output | HANDLE_W | Handle whose header is written |
| rel_valid | output | 1 | A list is released |
| rel_handle | output | HANDLE_W | Handle of the released list |
| fe_valid | output | 1 | A frame end was processed; the flags below are valid |
| fe_completed | output | 1 | The previous list completed at this frame end |
| fe_internal | output | 1 | The newly active list carried the internal flag |
| fe_writeback | output | 1 | The writeback capture of the active list ended |
| warn_replace | output | 1 | A pending list with the internal flag was dropped |

## Verification
Every cycle, the assertions check a set of structural properties. The frame-end logic and the commit logic never release or write a header in the same cycle. A pending list exists only beside a queued one, except in the last drain step. A warning always comes with a release. A single-shot frame end always completes. The drain steps follow one another in order.

Other behaviour depends on which handles come out and on what was stored earlier, and only the bench scenarios can show it. This covers the newest-wins replacement, completion slipping by one frame, writeback being reported only once, and the frame-end-first ordering of coincident events. The bench compares these against a reference model over directed and random sequences.

// File: rtl/fct_pkg.sv
// Shared types for the frame commit tracker.
package fct_pkg;
    parameter int unsigned HANDLE_W = 6;

    typedef logic [HANDLE_W-1:0] handle_t;

    // One tracker slot: occupancy, per-list flags and handle.
    typedef struct packed {
        logic    vld;
        logic    intl;
        logic    wb;
        handle_t hnd;
    } slot_t;

    // A strobe carrying a handle (release or header write).
    typedef struct packed {
        logic    vld;
        handle_t hnd;
    } strobe_t;

    typedef enum logic [1:0] {
        DR_IDLE    = 2'd0,
        DR_QUEUED  = 2'd1,
        DR_PENDING = 2'd2
    } drain_st_e;

    localparam slot_t   SLOT_EMPTY   = '0;
    localparam strobe_t STROBE_IDLE  = '0;
endpackage

// File: rtl/fct_frame_end.sv
// Frame-end step of the tracker (combinational).
// Computes the slot contents after a frame end, the release and header
// strobes it causes, and the report flags. It also tells the commit step
// whether the loader counts as busy.
// Assumes: at most one frame end per cycle; single_shot is stable around it.
module fct_frame_end
    import fct_pkg::*;
(
    input  logic    fe_i,
    input  logic    single_shot_i,
    input  logic    upd_pending_i,
    input  logic    bottom_i,
    input  slot_t   act_i,
    input  slot_t   que_i,
    input  slot_t   pen_i,
    output slot_t   act_o,
    output slot_t   que_o,
    output slot_t   pen_o,
    output strobe_t rel_o,
    output strobe_t hdr_o,
    output logic    completed_o,
    output logic    internal_o,
    output logic    writeback_o,
    output logic    loader_busy_o
);
    logic deferred;

    // Frame-end slot movement and flag reporting.
    always_comb begin
        act_o       = act_i;
        que_o       = que_i;
        pen_o       = pen_i;
        rel_o       = STROBE_IDLE;
        hdr_o       = STROBE_IDLE;
        completed_o = 1'b0;
        internal_o  = 1'b0;
        writeback_o = 1'b0;
        deferred    = (que_i.vld && upd_pending_i) || bottom_i;
        if (fe_i) begin
            if (single_shot_i) begin
                rel_o.vld   = act_i.vld;
                rel_o.hnd   = act_i.hnd;
                act_o       = SLOT_EMPTY;
                completed_o = 1'b1;
            end else if (!deferred) begin
                if (act_i.vld && act_i.wb) begin
                    writeback_o = 1'b1;
                    act_o.wb    = 1'b0;
                end
                if (que_i.vld) begin
                    internal_o  = que_i.intl;
                    rel_o.vld   = act_i.vld;
                    rel_o.hnd   = act_i.hnd;
                    act_o       = que_i;
                    act_o.intl  = 1'b0;
                    que_o       = SLOT_EMPTY;
                    completed_o = 1'b1;
                end
                if (pen_i.vld) begin
                    hdr_o.vld = 1'b1;
                    hdr_o.hnd = pen_i.hnd;
                    que_o     = pen_i;
                    pen_o     = SLOT_EMPTY;
                end
            end
        end
    end

    // The loader is busy if a queued header has not been taken yet.
    always_comb begin
        loader_busy_o = que_o.vld && (upd_pending_i || hdr_o.vld);
    end
endmodule

// File: rtl/fct_commit.sv
// Commit step of the tracker (combinational), applied after the frame-end step.
// Places a new list into the active, queued or pending slot by mode and by
// loader state, and produces the release, header and warning strobes.
// Assumes: slots given here already include the effect of any frame end.
module fct_commit
    import fct_pkg::*;
(
    input  logic    commit_i,
    input  logic    single_shot_i,
    input  logic    loader_busy_i,
    input  handle_t hnd_i,
    input  logic    intl_i,
    input  logic    wb_i,
    input  slot_t   act_i,
    input  slot_t   que_i,
    input  slot_t   pen_i,
    output slot_t   act_o,
    output slot_t   que_o,
    output slot_t   pen_o,
    output strobe_t rel_o,
    output strobe_t hdr_o,
    output logic    warn_o
);
    slot_t fresh;

    // Build the new slot image and route it.
    always_comb begin
        fresh.vld  = 1'b1;
        fresh.intl = intl_i;
        fresh.wb   = wb_i;
        fresh.hnd  = hnd_i;
        act_o      = act_i;
        que_o      = que_i;
        pen_o      = pen_i;
        rel_o      = STROBE_IDLE;
        hdr_o      = STROBE_IDLE;
        warn_o     = 1'b0;
        if (commit_i) begin
            if (single_shot_i) begin
                hdr_o.vld = 1'b1;
                hdr_o.hnd = hnd_i;
                act_o     = fresh;
            end else if (loader_busy_i) begin
                rel_o.vld = pen_i.vld;
                rel_o.hnd = pen_i.hnd;
                warn_o    = pen_i.vld && pen_i.intl;
                pen_o     = fresh;
            end else begin
                hdr_o.vld = 1'b1;
                hdr_o.hnd = hnd_i;
                rel_o.vld = que_i.vld;
                rel_o.hnd = que_i.hnd;
                que_o     = fresh;
            end
        end
    end
endmodule

// File: rtl/fct_drain_seq.sv
// Drain sequencer: three release steps (active, queued, pending).
// The first step happens in the cycle drain is seen; the others follow
// on the next two cycles. A drain request during a sequence is ignored.
module fct_drain_seq
    import fct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    output logic      rel_act_o,
    output logic      rel_que_o,
    output logic      rel_pen_o,
    output logic      busy_o,
    output drain_st_e st_o
);
    drain_st_e st_q;

    // Decode the step in progress.
    always_comb begin
        rel_act_o = (st_q == DR_IDLE) && start_i;
        rel_que_o = (st_q == DR_QUEUED);
        rel_pen_o = (st_q == DR_PENDING);
        busy_o    = rel_act_o || rel_que_o || rel_pen_o;
        st_o      = st_q;
    end

    // Advance through the drain steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= DR_IDLE;
        end else begin
            case (st_q)
                DR_IDLE:    st_q <= start_i ? DR_QUEUED : DR_IDLE;
                DR_QUEUED:  st_q <= DR_PENDING;
                default:    st_q <= DR_IDLE;
            endcase
        end
    end

    // R11: the queued step is always followed by the pending step
    a_r11_queued_then_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DR_QUEUED) |=> (st_q == DR_PENDING));

    // R11: the pending step ends the sequence
    a_r11_pending_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DR_PENDING) |=> (st_q == DR_IDLE));
endmodule

// File: rtl/fct_commit_tracker.sv
// Three-slot frame commit tracker (top).
// Holds the active, queued and pending lists. A frame end is applied first,
// then a commit, then all results are registered onto the output strobes,
// so every output appears one cycle after the inputs that caused it.
// Assumes: upd_pending mirrors the loader state for the queued header.
module fct_commit_tracker
    import fct_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                single_shot,
    input  logic                upd_pending,
    input  logic                bottom_field,
    input  logic                frame_end,
    input  logic                commit_valid,
    input  logic [HANDLE_W-1:0] commit_handle,
    input  logic                commit_internal,
    input  logic                commit_writeback,
    input  logic                drain,
    output logic                hdr_wr,
    output logic [HANDLE_W-1:0] hdr_handle,
    output logic                rel_valid,
    output logic [HANDLE_W-1:0] rel_handle,
    output logic                fe_valid,
    output logic                fe_completed,
    output logic                fe_internal,
    output logic                fe_writeback,
    output logic                warn_replace
);
    slot_t     act_q, que_q, pen_q;
    slot_t     fe_act, fe_que, fe_pen;
    slot_t     cm_act, cm_que, cm_pen;
    slot_t     act_n, que_n, pen_n;
    strobe_t   fe_rel, fe_hdr, cm_rel, cm_hdr, rel_n, hdr_n;
    logic      fe_cmp, fe_int, fe_wb, ld_busy, cm_warn;
    logic      dr_act, dr_que, dr_pen, dr_busy;
    logic      fe_go, cm_go;
    drain_st_e dr_st;

    // Drain has priority over frame end and commit.
    always_comb begin
        fe_go = frame_end && !dr_busy;
        cm_go = commit_valid && !dr_busy;
    end

    fct_drain_seq u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (drain),
        .rel_act_o (dr_act),
        .rel_que_o (dr_que),
        .rel_pen_o (dr_pen),
        .busy_o    (dr_busy),
        .st_o      (dr_st)
    );

    fct_frame_end u_fe (
        .fe_i          (fe_go),
        .single_shot_i (single_shot),
        .upd_pending_i (upd_pending),
        .bottom_i      (bottom_field),
        .act_i         (act_q),
        .que_i         (que_q),
        .pen_i         (pen_q),
        .act_o         (fe_act),
        .que_o         (fe_que),
        .pen_o         (fe_pen),
        .rel_o         (fe_rel),
        .hdr_o         (fe_hdr),
        .completed_o   (fe_cmp),
        .internal_o    (fe_int),
        .writeback_o   (fe_wb),
        .loader_busy_o (ld_busy)
    );

    fct_commit u_cm (
        .commit_i      (cm_go),
        .single_shot_i (single_shot),
        .loader_busy_i (ld_busy),
        .hnd_i         (commit_handle),
        .intl_i        (commit_internal),
        .wb_i          (commit_writeback),
        .act_i         (fe_act),
        .que_i         (fe_que),
        .pen_i         (fe_pen),
        .act_o         (cm_act),
        .que_o         (cm_que),
        .pen_o         (cm_pen),
        .rel_o         (cm_rel),
        .hdr_o         (cm_hdr),
        .warn_o        (cm_warn)
    );

    // Select the next slot image and strobes: drain step or normal path.
    always_comb begin
        act_n = cm_act;
        que_n = cm_que;
        pen_n = cm_pen;
        rel_n.vld = fe_rel.vld || cm_rel.vld;
        rel_n.hnd = fe_rel.vld ? fe_rel.hnd : cm_rel.hnd;
        hdr_n.vld = fe_hdr.vld || cm_hdr.vld;
        hdr_n.hnd = fe_hdr.vld ? fe_hdr.hnd : cm_hdr.hnd;
        if (dr_busy) begin
            act_n = act_q;
            que_n = que_q;
            pen_n = pen_q;
            hdr_n = STROBE_IDLE;
            rel_n = STROBE_IDLE;
            if (dr_act) begin
                rel_n.vld = act_q.vld;
                rel_n.hnd = act_q.hnd;
                act_n     = SLOT_EMPTY;
            end
            if (dr_que) begin
                rel_n.vld = que_q.vld;
                rel_n.hnd = que_q.hnd;
                que_n     = SLOT_EMPTY;
            end
            if (dr_pen) begin
                rel_n.vld = pen_q.vld;
                rel_n.hnd = pen_q.hnd;
                pen_n     = SLOT_EMPTY;
            end
        end
    end

    // Register slots and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q        <= SLOT_EMPTY;
            que_q        <= SLOT_EMPTY;
            pen_q        <= SLOT_EMPTY;
            hdr_wr       <= 1'b0;
            hdr_handle   <= '0;
            rel_valid    <= 1'b0;
            rel_handle   <= '0;
            fe_valid     <= 1'b0;
            fe_completed <= 1'b0;
            fe_internal  <= 1'b0;
            fe_writeback <= 1'b0;
            warn_replace <= 1'b0;
        end else begin
            act_q        <= act_n;
            que_q        <= que_n;
            pen_q        <= pen_n;
            hdr_wr       <= hdr_n.vld;
            hdr_handle   <= hdr_n.hnd;
            rel_valid    <= rel_n.vld;
            rel_handle   <= rel_n.hnd;
            fe_valid     <= fe_go;
            fe_completed <= fe_cmp;
            fe_internal  <= fe_int;
            fe_writeback <= fe_wb;
            warn_replace <= cm_warn && !dr_busy;
        end
    end

    // R12: frame-end and commit steps never release in the same cycle
    a_r12_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_rel.vld && cm_rel.vld));

    // R10: frame-end and commit steps never write a header in the same cycle
    a_r10_single_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_hdr.vld && cm_hdr.vld));

    // R3: a pending list only exists beside a queued list (outside the last drain step)
    a_r3_pending_has_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (pen_q.vld && dr_st != DR_PENDING) |-> que_q.vld);

    // R4: a replacement warning always comes with a release
    a_r4_warn_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        warn_replace |-> rel_valid);

    // R5: a single-shot frame end always reports completion
    a_r5_single_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && !fe_completed) |-> !$past(single_shot));
endmodule

// File: tb/fct_commit_tracker_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a reference model of the requirements kept in bench variables.
module fct_commit_tracker_tb;
    localparam int HW = fct_pkg::HANDLE_W;

    logic          clk = 1'b0;
    logic          rst_n, single_shot, upd_pending, bottom_field, frame_end;
    logic          commit_valid, commit_internal, commit_writeback, drain;
    logic [HW-1:0] commit_handle;
    logic          hdr_wr, rel_valid, fe_valid, fe_completed, fe_internal;
    logic          fe_writeback, warn_replace;
    logic [HW-1:0] hdr_handle, rel_handle;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic          a_v, a_i, a_w, q_v, q_i, q_w, p_v, p_i, p_w;
    logic [HW-1:0] a_h, q_h, p_h;
    int            m_dr;
    logic          e_hdr, e_rel, e_fev, e_cmp, e_int, e_wb, e_warn;
    logic [HW-1:0] e_hdr_h, e_rel_h;

    always #2 clk = ~clk;

    fct_commit_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .single_shot(single_shot),
        .upd_pending(upd_pending), .bottom_field(bottom_field),
        .frame_end(frame_end), .commit_valid(commit_valid),
        .commit_handle(commit_handle), .commit_internal(commit_internal),
        .commit_writeback(commit_writeback), .drain(drain),
        .hdr_wr(hdr_wr), .hdr_handle(hdr_handle), .rel_valid(rel_valid),
        .rel_handle(rel_handle), .fe_valid(fe_valid),
        .fe_completed(fe_completed), .fe_internal(fe_internal),
        .fe_writeback(fe_writeback), .warn_replace(warn_replace)
    );

    task automatic model_reset();
        {a_v, a_i, a_w, q_v, q_i, q_w, p_v, p_i, p_w} = '0;
        a_h = '0; q_h = '0; p_h = '0; m_dr = 0;
        {e_hdr, e_rel, e_fev, e_cmp, e_int, e_wb, e_warn} = '0;
        e_hdr_h = '0; e_rel_h = '0;
    endtask

    // Expected outputs of the coming edge, from the present inputs.
    task automatic model_step();
        logic busy;
        {e_hdr, e_rel, e_fev, e_cmp, e_int, e_wb, e_warn} = '0;
        e_hdr_h = '0; e_rel_h = '0;
        if (m_dr == 1) begin
            e_rel = q_v; e_rel_h = q_h; q_v = 0; m_dr = 2;
        end else if (m_dr == 2) begin
            e_rel = p_v; e_rel_h = p_h; p_v = 0; m_dr = 0;
        end else if (drain) begin
            e_rel = a_v; e_rel_h = a_h; a_v = 0; m_dr = 1;
        end else begin
            if (frame_end) begin
                e_fev = 1;
                if (single_shot) begin
                    e_rel = a_v; e_rel_h = a_h; a_v = 0; e_cmp = 1;
                end else if (!(q_v && upd_pending) && !bottom_field) begin
                    if (a_v && a_w) begin e_wb = 1; a_w = 0; end
                    if (q_v) begin
                        e_int = q_i;
                        e_rel = a_v; e_rel_h = a_h;
                        a_v = 1; a_h = q_h; a_i = 0; a_w = q_w;
                        q_v = 0; e_cmp = 1;
                    end
                    if (p_v) begin
                        e_hdr = 1; e_hdr_h = p_h;
                        q_v = 1; q_h = p_h; q_i = p_i; q_w = p_w; p_v = 0;
                    end
                end
            end
            busy = q_v && (upd_pending || e_hdr);
            if (commit_valid) begin
                if (single_shot) begin
                    e_hdr = 1; e_hdr_h = commit_handle;
                    a_v = 1; a_h = commit_handle; a_i = commit_internal; a_w = commit_writeback;
                end else if (busy) begin
                    if (p_v) begin e_rel = 1; e_rel_h = p_h; e_warn = p_i; end
                    p_v = 1; p_h = commit_handle; p_i = commit_internal; p_w = commit_writeback;
                end else begin
                    e_hdr = 1; e_hdr_h = commit_handle;
                    if (q_v) begin e_rel = 1; e_rel_h = q_h; end
                    q_v = 1; q_h = commit_handle; q_i = commit_internal; q_w = commit_writeback;
                end
            end
        end
    endtask

    task automatic check(input string tag);
        logic [2*HW+6:0] got, exp;
        got = {hdr_wr, hdr_wr ? hdr_handle : '0, rel_valid, rel_valid ? rel_handle : '0,
               fe_valid, fe_completed, fe_internal, fe_writeback, warn_replace};
        exp = {e_hdr, e_hdr ? e_hdr_h : '0, e_rel, e_rel ? e_rel_h : '0,
               e_fev, e_cmp, e_int, e_wb, e_warn};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h (hdr,h,rel,h,fev,cmp,int,wb,warn)",
                     tag, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check after the next rising edge.
    task automatic cyc(input string tag, input bit c, input logic [HW-1:0] h,
                       input bit ci, input bit cw, input bit fe, input bit up,
                       input bit bot, input bit dr);
        commit_valid = c; commit_handle = h; commit_internal = ci;
        commit_writeback = cw; frame_end = fe; upd_pending = up;
        bottom_field = bot; drain = dr;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag);
        commit_valid = 0; frame_end = 0; drain = 0; bottom_field = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; single_shot = 0; upd_pending = 0; bottom_field = 0;
        frame_end = 0; commit_valid = 0; commit_handle = '0;
        commit_internal = 0; commit_writeback = 0; drain = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset outputs");
        rst_n = 1;
        cyc("R1 empty frame end",       0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R2 commit to loader",      1, 1, 0, 0, 0, 0, 0, 0);
        cyc("R3 commit while busy",     1, 2, 1, 0, 0, 1, 0, 0);
        cyc("R4 replace internal",      1, 3, 0, 0, 0, 1, 0, 0);
        cyc("R6 deferred frame end",    0, 0, 0, 0, 1, 1, 0, 0);
        cyc("R7 bottom field",          0, 0, 0, 0, 1, 0, 1, 0);
        cyc("R10 pending to loader",    0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R2 replace queued",        1, 4, 1, 1, 0, 0, 0, 0);
        cyc("R9 promote internal",      0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R8 writeback reported",    0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R8 writeback cleared",     0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R13 upd ignored",          1, 5, 0, 0, 0, 1, 0, 0);
        cyc("R12 same cycle empty",     1, 6, 0, 0, 1, 0, 0, 0);
        cyc("R3 park pending",          1, 7, 0, 0, 0, 1, 0, 0);
        cyc("R12 same cycle pending",   1, 8, 0, 0, 1, 0, 0, 0);
        cyc("R11 drain active",         1, 9, 0, 0, 0, 0, 0, 1);
        cyc("R11 drain queued",         1, 9, 0, 0, 1, 0, 0, 0);
        cyc("R11 drain pending",        0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R11 slots empty",          0, 0, 0, 0, 1, 0, 0, 0);
        single_shot = 1;
        cyc("R5 single commit",         1, 10, 0, 0, 0, 1, 0, 0);
        cyc("R5 single frame end",      0, 0, 0, 0, 1, 1, 1, 0);
        cyc("R5 single empty end",      0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R5 single same cycle",     1, 11, 0, 0, 1, 0, 0, 0);
        cyc("R5 single retire",         0, 0, 0, 0, 1, 0, 0, 0);
        single_shot = 0;
        for (int n = 0; n < 4000; n++) begin
            if (n % 700 == 699) single_shot = ~single_shot;
            cyc("R12 random",
                ($urandom_range(0, 2) == 0), HW'($urandom),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 5) == 0), ($urandom_range(0, 99) == 0));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule